// File: doc/BRIEF.md
# Power-Down Clock Shutdown Sequencer

This block shuts down and restarts a clock generator's outputs in order, under the control of a single dual-role control pin. After reset the pin means "supply good" and is active low. The first time the block sees it low, the block arms. From then on the same pin is an active-high power-down request. The pin is asynchronous. The block brings it into the CPU complement clock domain through a synchronizer. It accepts a request only when the synchronized level is high on two edges in a row.

Once a request is accepted, each single-ended output is parked low. The park happens only while its raw clock is low, so no high phase is cut short. Each differential lane is parked while its complement leg is low. A per-group drive-mode bit picks the parked form of a differential lane. With the bit at 0, the true leg is driven high and the complement leg is released. With the bit at 1, both legs are released. A lane whose clock does not move is forced to park after a bounded number of cycles. One cycle after every output is parked, the block tells the oscillator and PLL that they may power off. When the request is withdrawn, that permission drops at once. The outputs stay parked until the PLL reports lock, and then they all come back on the same edge. The selectable 96/100 lane uses the DOT group's drive mode when it runs at 96 MHz and the SRC group's drive mode when it runs at 100 MHz.

Top module: `pd_seq_top`

## Requirements
- R1: Before the synchronized pin has been seen low, a high pin never starts a shutdown. `oscOff` stays 0 and every output stays parked. The first low sample arms the block.
- R2: After arming or after a release, outputs stay parked while `pllLock` is 0. They leave the parked state on the edge after `pllLock` is seen high.
- R3: After arming, a request is accepted only when the synchronized pin is high on two consecutive clock edges. A pin pulse that lasts one clock period is ignored and the outputs keep running.
- R4: After acceptance, each bit of `seOut` is held at 0. It is parked only on an edge where its raw input is low, unless the lane is forced.
- R5: After acceptance, each differential lane parks on an edge where its raw true input is high, which means its complement leg is low. Any lane still unparked after PARK_LIMIT (default 4) cycles is forced. `oscOff` rises between 6 and 9 clock periods after the pin rises.
- R6: `driveMode` bit 0 belongs to the CPU lane (diff index 0), bit 1 to the SRC lane (index 1) and bit 2 to the DOT lane (index 2).
  - A parked lane with its bit at 0 shows `diffT`=1, `diffTOe`=1, `diffCOe`=0.
  - A parked lane with its bit at 1 shows `diffTOe`=0 and `diffCOe`=0.
  - A running lane shows `diffT`=raw, `diffC`=~raw and both enables at 1.
- R7: Diff lane 3 is the selectable lane. It takes the DOT drive-mode bit when `sel96`=1 and the SRC bit when `sel96`=0.
- R8: `oscOff` rises exactly one cycle after all outputs report parked. It is high only while every output is parked.
- R9: When the synchronized pin goes low during power-off, `oscOff` falls on that same edge. All outputs then return on a single edge once lock is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU complement clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrPin | input | 1 | Dual-role pin: active-low supply good, then active-high power-down request |
| pllLock | input | 1 | PLL lock indication |
| sel96 | input | 1 | 1 selects 96 MHz (DOT-style) for lane 3, 0 selects 100 MHz (SRC-style) |
| driveMode | input | 3 | Parked-form bit per group: [0] CPU, [1] SRC, [2] DOT |
| seRaw | input | NUM_SE | Raw single-ended clocks |
| diffRaw | input | 4 | Raw true-leg clocks of the differential lanes |
| seOut | output | NUM_SE | Gated single-ended outputs |
| diffT | output | 4 | True-leg values |
| diffTOe | output | 4 | True-leg drive enables |
| diffC | output | 4 | Complement-leg values |
| diffCOe | output | 4 | Complement-leg drive enables |
| oscOff | output | 1 | Oscillator and PLL may power off |

## Verification
The pin is driven with several patterns, and each one separates a different behaviour:
- A high level held from power-up tells the supply-good meaning apart from a request.
- A pulse of one period shows that the two-edge confirmation rejects short pulses.
- A sustained high level runs the full shutdown.

Shutdowns run with different drive-mode words and both `sel96` settings. This shows that each lane takes its parked form from its own group bit, and that the selectable lane switches groups.

One differential lane is held still to exercise the forced park and its worst-case timing. Releases with lock present and with lock absent tell the immediate drop of `oscOff` apart from the lock-gated return of the outputs.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int DIFF_LANES = 4;
  localparam int LANE_CPU = 0;
  localparam int LANE_SRC = 1;
  localparam int LANE_DOT = 2;
  localparam int LANE_SEL = 3;

  typedef enum logic [2:0] {
    ST_WAITPG = 3'd0,
    ST_RELOCK = 3'd1,
    ST_RUN    = 3'd2,
    ST_PARK   = 3'd3,
    ST_OFF    = 3'd4
  } seqState_t;

  typedef struct packed {
    logic parkReq;
    logic forcePark;
    logic releaseAll;
  } gateCtl_t;
endpackage

// File: rtl/pd_seq_ctrl.sv
module pd_seq_ctrl
  import pd_seq_pkg::*;
#(
  parameter int PARK_LIMIT  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pwrPin,
  input  logic     pllLock,
  input  logic     allParked,
  output gateCtl_t ctl,
  output logic     oscOff,
  output logic     armed
);
  localparam int CNT_W = $clog2(PARK_LIMIT + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;
  logic                   pinPrev;
  logic                   confirmed;
  seqState_t              state, stateNext;
  logic [CNT_W-1:0]       parkCnt;

  // synchronizer resets to "supply not good"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], pwrPin};
      pinPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinSync   = syncQ[SYNC_STAGES-1];
  assign confirmed = pinSync && pinPrev;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_WAITPG: if (!pinSync) stateNext = ST_RELOCK;
      ST_RELOCK: begin
        if (confirmed)    stateNext = ST_PARK;
        else if (pllLock) stateNext = ST_RUN;
      end
      ST_RUN:    if (confirmed) stateNext = ST_PARK;
      ST_PARK:   if (allParked) stateNext = ST_OFF;
      ST_OFF:    if (!pinSync)  stateNext = ST_RELOCK;
      default:   stateNext = ST_WAITPG;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAITPG;
      parkCnt <= '0;
    end else begin
      state <= stateNext;
      if (state != ST_PARK) parkCnt <= '0;
      else if (parkCnt != CNT_W'(PARK_LIMIT)) parkCnt <= parkCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.parkReq    = (state == ST_PARK);
    ctl.forcePark  = (state == ST_PARK) && (parkCnt == CNT_W'(PARK_LIMIT - 1));
    ctl.releaseAll = (state == ST_RELOCK) && pllLock && !confirmed;
  end

  assign oscOff = (state == ST_OFF) && pinSync;
  assign armed  = (state != ST_WAITPG);
endmodule

// File: rtl/pd_seq_gate.sv
module pd_seq_gate
  import pd_seq_pkg::*;
#(
  parameter int NUM_SE = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gateCtl_t              ctl,
  input  logic [NUM_SE-1:0]     seRaw,
  input  logic [DIFF_LANES-1:0] diffRaw,
  input  logic [DIFF_LANES-1:0] laneMode,
  output logic [NUM_SE-1:0]     seOut,
  output logic [DIFF_LANES-1:0] diffT,
  output logic [DIFF_LANES-1:0] diffTOe,
  output logic [DIFF_LANES-1:0] diffC,
  output logic [DIFF_LANES-1:0] diffCOe,
  output logic                  allParked
);
  logic [NUM_SE-1:0]     seParked;
  logic [DIFF_LANES-1:0] diffParked;

  for (genvar i = 0; i < NUM_SE; i++) begin : g_se
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 seParked[i] <= 1'b1;
      else if (ctl.releaseAll)   seParked[i] <= 1'b0;
      else if (ctl.parkReq && (!seRaw[i] || ctl.forcePark))
                                 seParked[i] <= 1'b1;
    end
    assign seOut[i] = seRaw[i] & ~seParked[i];
  end

  for (genvar j = 0; j < DIFF_LANES; j++) begin : g_diff
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 diffParked[j] <= 1'b1;
      else if (ctl.releaseAll)   diffParked[j] <= 1'b0;
      else if (ctl.parkReq && (diffRaw[j] || ctl.forcePark))
                                 diffParked[j] <= 1'b1;
    end
    always_comb begin
      if (diffParked[j]) begin
        diffT[j]   = ~laneMode[j];
        diffTOe[j] = ~laneMode[j];
        diffC[j]   = 1'b0;
        diffCOe[j] = 1'b0;
      end else begin
        diffT[j]   = diffRaw[j];
        diffTOe[j] = 1'b1;
        diffC[j]   = ~diffRaw[j];
        diffCOe[j] = 1'b1;
      end
    end
  end

  assign allParked = (&seParked) & (&diffParked);
endmodule

// File: rtl/pd_seq_top.sv
module pd_seq_top
  import pd_seq_pkg::*;
#(
  parameter int NUM_SE      = 3,
  parameter int PARK_LIMIT  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pwrPin,
  input  logic                  pllLock,
  input  logic                  sel96,
  input  logic [2:0]            driveMode,
  input  logic [NUM_SE-1:0]     seRaw,
  input  logic [DIFF_LANES-1:0] diffRaw,
  output logic [NUM_SE-1:0]     seOut,
  output logic [DIFF_LANES-1:0] diffT,
  output logic [DIFF_LANES-1:0] diffTOe,
  output logic [DIFF_LANES-1:0] diffC,
  output logic [DIFF_LANES-1:0] diffCOe,
  output logic                  oscOff
);
  gateCtl_t              ctl;
  logic                  allParked;
  logic                  armed;
  logic [DIFF_LANES-1:0] laneMode;

  always_comb begin
    laneMode[LANE_CPU] = driveMode[0];
    laneMode[LANE_SRC] = driveMode[1];
    laneMode[LANE_DOT] = driveMode[2];
    laneMode[LANE_SEL] = sel96 ? driveMode[2] : driveMode[1];
  end

  pd_seq_ctrl #(.PARK_LIMIT(PARK_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrPin(pwrPin), .pllLock(pllLock),
    .allParked(allParked), .ctl(ctl), .oscOff(oscOff), .armed(armed)
  );

  pd_seq_gate #(.NUM_SE(NUM_SE)) u_gate (
    .clk(clk), .rstN(rstN), .ctl(ctl), .seRaw(seRaw), .diffRaw(diffRaw),
    .laneMode(laneMode), .seOut(seOut), .diffT(diffT), .diffTOe(diffTOe),
    .diffC(diffC), .diffCOe(diffCOe), .allParked(allParked)
  );
endmodule

// File: rtl/pd_seq_chk.sv
module pd_seq_chk
  import pd_seq_pkg::*;
#(
  parameter int NUM_SE     = 3,
  parameter int PARK_LIMIT = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_SE-1:0]     seRaw,
  input logic [NUM_SE-1:0]     seOut,
  input logic [DIFF_LANES-1:0] diffCOe,
  input logic                  oscOff,
  input logic                  allParked,
  input logic                  armed,
  input gateCtl_t              ctl
);
  localparam int CW = $clog2(PARK_LIMIT + 2);
  logic [CW-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= '0;
    else if (ctl.parkReq && !allParked) begin
      if (waitCnt != CW'(PARK_LIMIT + 1)) waitCnt <= waitCnt + 1'b1;
    end else waitCnt <= '0;
  end

  for (genvar i = 0; i < NUM_SE; i++) begin : g_se_chk
    // R4
    se_low_park_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(seOut[i]) |-> (!seRaw[i] || $past(ctl.forcePark)));
  end

  // R5
  park_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.parkReq && !allParked) |-> (waitCnt < CW'(PARK_LIMIT)));

  // R8
  osc_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscOff) |-> $past(allParked));

  // R8
  osc_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    oscOff |-> (allParked && seOut == '0 && diffCOe == '0));

  // R1
  unarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!oscOff && allParked));
endmodule

bind pd_seq_top pd_seq_chk #(.NUM_SE(NUM_SE), .PARK_LIMIT(PARK_LIMIT)) u_chk (
  .clk(clk), .rstN(rstN), .seRaw(seRaw), .seOut(seOut), .diffCOe(diffCOe),
  .oscOff(oscOff), .allParked(allParked), .armed(armed), .ctl(ctl)
);

// File: tb/pd_seq_top_tb.sv
module pd_seq_top_tb;
  localparam int NSE = 3;

  logic clk = 0, rstN = 0, pwrPin = 1, pllLock = 0, sel96 = 0, stall = 0;
  logic [2:0] driveMode = 3'b000;
  logic [NSE-1:0] seRaw = '0;
  logic [3:0] diffRaw = '0;
  logic [NSE-1:0] seOut;
  logic [3:0] diffT, diffTOe, diffC, diffCOe;
  logic oscOff;
  int checks = 0, fails = 0;
  logic [7:0] cnt = '0;

  pd_seq_top #(.NUM_SE(NSE)) u_dut (
    .clk(clk), .rstN(rstN), .pwrPin(pwrPin), .pllLock(pllLock), .sel96(sel96),
    .driveMode(driveMode), .seRaw(seRaw), .diffRaw(diffRaw), .seOut(seOut),
    .diffT(diffT), .diffTOe(diffTOe), .diffC(diffC), .diffCOe(diffCOe),
    .oscOff(oscOff)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cnt     <= cnt + 1'b1;
    seRaw   <= cnt[NSE-1:0];
    diffRaw <= {cnt[0], cnt[2], cnt[1], stall ? 1'b0 : cnt[0]};
  end

  task automatic chk(input bit ok, input string req, input string msg,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, msg, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic bit isLive();
    return seOut == seRaw && diffT == diffRaw && diffC == ~diffRaw &&
           diffTOe == 4'hF && diffCOe == 4'hF;
  endfunction

  function automatic bit isParked(input logic [3:0] m);
    return seOut == '0 && diffCOe == 4'h0 && diffTOe == ~m && diffT == ~m;
  endfunction

  function automatic logic [3:0] laneModes();
    return {sel96 ? driveMode[2] : driveMode[1], driveMode[2], driveMode[1], driveMode[0]};
  endfunction

  task automatic t_powerup();
    step(20);
    chk(oscOff == 0, "R1", "oscOff during supply-not-good", oscOff, 0);
    chk(isParked(laneModes()), "R1", "outputs held before arming", seOut, 0);
    @(negedge clk); pwrPin = 0;
    step(10);
    chk(isParked(laneModes()), "R2", "outputs held without lock", diffCOe, 0);
    @(negedge clk); pllLock = 1;
    step(3);
    chk(isLive(), "R2", "outputs live after lock", diffCOe, 15);
  endtask

  task automatic t_glitch();
    @(negedge clk); pwrPin = 1;
    @(negedge clk); pwrPin = 0;
    step(12);
    chk(oscOff == 0, "R3", "one-cycle pulse oscOff", oscOff, 0);
    chk(isLive(), "R3", "one-cycle pulse outputs live", diffCOe, 15);
  endtask

  task automatic t_shutdown(input logic [2:0] dm, input logic s96,
                            input int lo, input int hi, input string rq);
    int k = 0;
    driveMode = dm; sel96 = s96;
    @(negedge clk); pwrPin = 1;
    while (!oscOff && k < 30) begin step(1); k++; end
    chk(k >= lo && k <= hi, rq, "oscOff delay from pin rise", k, hi);
    chk(isParked(laneModes()), "R6", "parked leg forms", {diffTOe, diffCOe}, {~laneModes(), 4'h0});
    chk(seOut == '0, "R4", "single-ended parked low", seOut, 0);
    chk(diffTOe[3] == ~(s96 ? dm[2] : dm[1]), "R7", "selectable lane group", diffTOe[3],
        ~(s96 ? dm[2] : dm[1]));
    step(5);
    chk(oscOff == 1, "R8", "oscOff held while requested", oscOff, 1);
  endtask

  task automatic t_release_lock();
    @(negedge clk); pwrPin = 0;
    step(1);
    chk(oscOff == 1, "R9", "oscOff before sync", oscOff, 1);
    step(1);
    chk(oscOff == 0, "R9", "oscOff drops on sync edge", oscOff, 0);
    step(2);
    chk(isLive(), "R9", "all outputs back together", diffCOe, 15);
  endtask

  task automatic t_release_nolock();
    pllLock = 0;
    @(negedge clk); pwrPin = 0;
    step(10);
    chk(oscOff == 0, "R9", "oscOff low after release", oscOff, 0);
    chk(isParked(laneModes()), "R2", "still parked without lock", diffCOe, 0);
    @(negedge clk); pllLock = 1;
    step(3);
    chk(isLive(), "R2", "live after relock", diffCOe, 15);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        chk(oscOff == 0, "R1", "reset oscOff", oscOff, 0);
        t_powerup();
        t_glitch();
        t_shutdown(3'b010, 1'b0, 6, 9, "R5");
        t_release_lock();
        stall = 1;
        step(2);
        t_shutdown(3'b100, 1'b1, 9, 9, "R5");
        t_release_nolock();
        stall = 0;
        t_shutdown(3'b001, 1'b0, 6, 9, "R5");
        t_release_lock();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule